// File: doc/BRIEF.md
# Partial-Bypass Hazard and Forwarding Controller

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback) whose forwarding network has only two paths. The memory-stage result can be steered into the first ALU operand, and the writeback-stage result can be steered into the second ALU operand. No other bypass exists. The register file returns a value written in the same cycle, so a producer that has reached writeback never needs a stall.

Every cycle the controller looks at the register fields the decode instruction reads and at the destination, write and load flags of the instructions in execute and memory. It then decides whether the decode instruction may advance. If it may, it records which operand mux select each execute-stage operand will need. If it may not, it freezes the PC and the fetch/decode register and turns the next execute-stage slot into a bubble. The selects are stored alongside the instruction as it enters execute, so the operand muxes see a stable value for the whole cycle.

Top module: `hzd_fwd_unit`

## Requirements
- R1: When the execute-stage instruction writes the register named by a used first source, and that instruction is not a load, there is no stall and `fwdSelA` is 1 in the following cycle.
- R2: When the execute-stage instruction is a load that writes a used first source, the decode instruction stalls.
- R3: When the memory-stage instruction writes a used first source and the execute-stage instruction does not, the decode instruction stalls, because no bypass from writeback into the first operand exists.
- R4: When the execute-stage instruction writes a used second source, the decode instruction stalls, whether or not that producer is a load.
- R5: When the memory-stage instruction writes a used second source and the execute-stage instruction does not, there is no stall and `fwdSelB` is 1 in the following cycle, even if the producer was a load.
- R6: Register 0, a source whose use flag is 0, and a producer whose write flag is 0 never cause a stall or a forward select.
- R7: While stalling, `pcWrite` and `ifIdWrite` are 0 and `idExBubble` is 1. Otherwise they are 1, 1 and 0.
- R8: The selects are registered. The value chosen in a cycle appears after the next rising clock edge. After a stall cycle both selects are 0, and reset (active-low `rstN`, asynchronous) sets both to 0.
- R9: With no dependence on execute or memory producers, both selects are 0 (0 means the register-file value, 1 means the single bypass source for that operand).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idRs | input | REG_AW | First source register of the decode instruction |
| idRt | input | REG_AW | Second source register of the decode instruction |
| idUseRs | input | 1 | Decode instruction reads its first source |
| idUseRt | input | 1 | Decode instruction reads its second source |
| exRd | input | REG_AW | Destination of the execute-stage instruction |
| exRegWrite | input | 1 | Execute-stage instruction writes a register |
| exMemRead | input | 1 | Execute-stage instruction is a load |
| memRd | input | REG_AW | Destination of the memory-stage instruction |
| memRegWrite | input | 1 | Memory-stage instruction writes a register |
| pcWrite | output | 1 | PC update enable |
| ifIdWrite | output | 1 | Fetch/decode register load enable |
| idExBubble | output | 1 | Load a no-op into the decode/execute register |
| fwdSelA | output | 1 | Registered first-operand select (1 = memory-stage result) |
| fwdSelB | output | 1 | Registered second-operand select (1 = writeback result) |

## Verification
The bench builds the block with the default five-bit register address, so it can use every register number, including register 0 as an explicit case. Table vectors place same-register producers in execute and memory at the same time, mix loads with ALU producers on each operand, and combine one operand that forwards with another that stalls. This shows that a stall beats any forward. A directed run follows one load through two stall cycles and then checks the register-file-only pass, and a reset applied mid-run checks that the selects clear.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef struct packed {
    logic stall;
    logic selA;
    logic selB;
  } hzdCtrlT;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] src,
  input  logic              srcUsed,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exRegWrite,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWrite,
  output logic              hitEx,
  output logic              hitMem
);
  localparam logic [REG_AW-1:0] ZERO_REG = '0;

  logic live;
  assign live   = srcUsed && (src != ZERO_REG);
  assign hitEx  = live && exRegWrite  && (exRd  == src);
  assign hitMem = live && memRegWrite && (memRd == src);
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] idRs,
  input  logic [REG_AW-1:0] idRt,
  input  logic              idUseRs,
  input  logic              idUseRt,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exRegWrite,
  input  logic              exMemRead,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWrite,
  output hzdCtrlT           ctrl
);
  localparam int N_SRC = 2;
  localparam int SRC_A = 0;
  localparam int SRC_B = 1;

  logic [N_SRC-1:0][REG_AW-1:0] srcVec;
  logic [N_SRC-1:0]             srcUse;
  logic [N_SRC-1:0]             hitEx;
  logic [N_SRC-1:0]             hitMem;

  assign srcVec = {idRt, idRs};
  assign srcUse = {idUseRt, idUseRs};

  for (genvar g = 0; g < N_SRC; g++) begin : gMatch
    hzd_src_match #(.REG_AW(REG_AW)) uMatch (
      .src        (srcVec[g]),
      .srcUsed    (srcUse[g]),
      .exRd       (exRd),
      .exRegWrite (exRegWrite),
      .memRd      (memRd),
      .memRegWrite(memRegWrite),
      .hitEx      (hitEx[g]),
      .hitMem     (hitMem[g])
    );
  end

  logic stallA, stallB;

  always_comb begin
    // first operand: bypass only from memory stage next cycle
    stallA = (hitEx[SRC_A] && exMemRead) || (hitMem[SRC_A] && !hitEx[SRC_A]);
    // second operand: bypass only from writeback next cycle
    stallB = hitEx[SRC_B];
    ctrl.stall = stallA || stallB;
    ctrl.selA  = hitEx[SRC_A] && !exMemRead;
    ctrl.selB  = hitMem[SRC_B] && !hitEx[SRC_B];
  end
endmodule

// File: rtl/hzd_sel_regs.sv
module hzd_sel_regs
  import hzd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  hzdCtrlT ctrl,
  output logic    pcWrite,
  output logic    ifIdWrite,
  output logic    idExBubble,
  output logic    fwdSelA,
  output logic    fwdSelB
);
  assign pcWrite    = !ctrl.stall;
  assign ifIdWrite  = !ctrl.stall;
  assign idExBubble =  ctrl.stall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fwdSelA <= 1'b0;
      fwdSelB <= 1'b0;
    end else if (ctrl.stall) begin
      fwdSelA <= 1'b0;
      fwdSelB <= 1'b0;
    end else begin
      fwdSelA <= ctrl.selA;
      fwdSelB <= ctrl.selB;
    end
  end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
  import hzd_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] idRs,
  input  logic [REG_AW-1:0] idRt,
  input  logic              idUseRs,
  input  logic              idUseRt,
  input  logic [REG_AW-1:0] exRd,
  input  logic              exRegWrite,
  input  logic              exMemRead,
  input  logic [REG_AW-1:0] memRd,
  input  logic              memRegWrite,
  output logic              pcWrite,
  output logic              ifIdWrite,
  output logic              idExBubble,
  output logic              fwdSelA,
  output logic              fwdSelB
);
  hzdCtrlT ctrl;

  hzd_ctrl #(.REG_AW(REG_AW)) uCtrl (
    .idRs(idRs), .idRt(idRt), .idUseRs(idUseRs), .idUseRt(idUseRt),
    .exRd(exRd), .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite), .ctrl(ctrl)
  );

  hzd_sel_regs uRegs (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .pcWrite(pcWrite), .ifIdWrite(ifIdWrite), .idExBubble(idExBubble),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB)
  );

  localparam logic [REG_AW-1:0] R0 = '0;

  logic rsLive, rtLive;
  assign rsLive = idUseRs && (idRs != R0);
  assign rtLive = idUseRt && (idRt != R0);

  a_r2_load_rs_stall: assert property (@(posedge clk) disable iff (!rstN)
    (rsLive && exRegWrite && exMemRead && exRd == idRs) |-> idExBubble);

  a_r4_rt_ex_stall: assert property (@(posedge clk) disable iff (!rstN)
    (rtLive && exRegWrite && exRd == idRt) |-> (idExBubble && !pcWrite));

  a_r1_rs_forward: assert property (@(posedge clk) disable iff (!rstN)
    (rsLive && exRegWrite && !exMemRead && exRd == idRs && !idExBubble) |=> fwdSelA);

  a_r5_rt_forward: assert property (@(posedge clk) disable iff (!rstN)
    (rtLive && memRegWrite && memRd == idRt && !(exRegWrite && exRd == idRt)
     && !idExBubble) |=> fwdSelB);

  a_r8_bubble_clears: assert property (@(posedge clk) disable iff (!rstN)
    idExBubble |=> (!fwdSelA && !fwdSelB));

  a_r6_no_sources: assert property (@(posedge clk) disable iff (!rstN)
    (!rsLive && !rtLive) |-> (!idExBubble && pcWrite && ifIdWrite));
endmodule

// File: tb/sim_hzd_fwd_unit.sv
module sim_hzd_fwd_unit;
  localparam int PERIOD = 10;
  localparam int AW = 5;

  typedef struct packed {
    logic [AW-1:0] rs; logic [AW-1:0] rt; logic useRs; logic useRt;
    logic [AW-1:0] exRd; logic exRw; logic exLd;
    logic [AW-1:0] memRd; logic memRw;
    logic stall; logic selA; logic selB;
  } vecT;

  localparam int NV = 14;
  localparam vecT VEC [NV] = '{
    '{5'd1,  5'd2,  1'b1,1'b1, 5'd3,  1'b1,1'b0, 5'd4,  1'b1, 1'b0,1'b0,1'b0}, // R9 none
    '{5'd5,  5'd6,  1'b1,1'b1, 5'd5,  1'b1,1'b0, 5'd7,  1'b1, 1'b0,1'b1,1'b0}, // R1
    '{5'd5,  5'd6,  1'b1,1'b1, 5'd5,  1'b1,1'b1, 5'd7,  1'b1, 1'b1,1'b0,1'b0}, // R2
    '{5'd8,  5'd6,  1'b1,1'b1, 5'd3,  1'b1,1'b0, 5'd8,  1'b1, 1'b1,1'b0,1'b0}, // R3
    '{5'd2,  5'd9,  1'b1,1'b1, 5'd9,  1'b1,1'b0, 5'd4,  1'b1, 1'b1,1'b0,1'b0}, // R4 alu
    '{5'd2,  5'd9,  1'b1,1'b1, 5'd9,  1'b1,1'b1, 5'd4,  1'b1, 1'b1,1'b0,1'b0}, // R4 load
    '{5'd2,  5'd10, 1'b1,1'b1, 5'd3,  1'b1,1'b0, 5'd10, 1'b1, 1'b0,1'b0,1'b1}, // R5
    '{5'd11, 5'd12, 1'b1,1'b1, 5'd11, 1'b1,1'b0, 5'd12, 1'b1, 1'b0,1'b1,1'b1}, // R1 R5
    '{5'd0,  5'd0,  1'b1,1'b1, 5'd0,  1'b1,1'b1, 5'd0,  1'b1, 1'b0,1'b0,1'b0}, // R6 zero
    '{5'd5,  5'd9,  1'b0,1'b0, 5'd5,  1'b1,1'b1, 5'd9,  1'b1, 1'b0,1'b0,1'b0}, // R6 unused
    '{5'd5,  5'd6,  1'b1,1'b1, 5'd5,  1'b0,1'b1, 5'd5,  1'b0, 1'b0,1'b0,1'b0}, // R6 no write
    '{5'd13, 5'd1,  1'b1,1'b0, 5'd13, 1'b1,1'b0, 5'd13, 1'b1, 1'b0,1'b1,1'b0}, // R1 newest wins
    '{5'd1,  5'd14, 1'b0,1'b1, 5'd14, 1'b1,1'b0, 5'd14, 1'b1, 1'b1,1'b0,1'b0}, // R4 both stages
    '{5'd15, 5'd16, 1'b1,1'b1, 5'd15, 1'b1,1'b1, 5'd16, 1'b1, 1'b1,1'b0,1'b0}  // R8 stall beats fwd
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] idRs = '0, idRt = '0, exRd = '0, memRd = '0;
  logic idUseRs = 1'b0, idUseRt = 1'b0, exRegWrite = 1'b0, exMemRead = 1'b0, memRegWrite = 1'b0;
  logic pcWrite, ifIdWrite, idExBubble, fwdSelA, fwdSelB;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  hzd_fwd_unit #(.REG_AW(AW)) u0 (
    .clk(clk), .rstN(rstN), .idRs(idRs), .idRt(idRt), .idUseRs(idUseRs), .idUseRt(idUseRt),
    .exRd(exRd), .exRegWrite(exRegWrite), .exMemRead(exMemRead),
    .memRd(memRd), .memRegWrite(memRegWrite),
    .pcWrite(pcWrite), .ifIdWrite(ifIdWrite), .idExBubble(idExBubble),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vecT v);
    idRs = v.rs; idRt = v.rt; idUseRs = v.useRs; idUseRt = v.useRt;
    exRd = v.exRd; exRegWrite = v.exRw; exMemRead = v.exLd;
    memRd = v.memRd; memRegWrite = v.memRw;
  endtask

  // apply at negedge, check strobes, then selects after the next posedge
  task automatic runVec(input vecT v, input string tag);
    @(negedge clk);
    drive(v);
    #1;
    chk({tag, " R7 bubble"}, int'(idExBubble), int'(v.stall));
    chk({tag, " R7 pc/ifid"}, int'({pcWrite, ifIdWrite}), v.stall ? 0 : 3);
    @(negedge clk);
    chk({tag, " R8 selA"}, int'(fwdSelA), v.stall ? 0 : int'(v.selA));
    chk({tag, " R8 selB"}, int'(fwdSelB), v.stall ? 0 : int'(v.selB));
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    // reset state, R8
    #(PERIOD * 2 + 2);
    chk("R8 reset selA", int'(fwdSelA), 0);
    chk("R8 reset selB", int'(fwdSelB), 0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) runVec(VEC[i], $sformatf("vec%0d", i));

    // load-use on first operand: two stalls, then register file path (R2 R3)
    runVec('{5'd7, 5'd1, 1'b1, 1'b0, 5'd7, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0}, "seq R2");
    runVec('{5'd7, 5'd1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd7, 1'b1, 1'b1, 1'b0, 1'b0}, "seq R3");
    runVec('{5'd7, 5'd1, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0, 1'b0}, "seq R9");

    // second operand after a one-cycle stall gets writeback bypass (R4 R5)
    runVec('{5'd1, 5'd20, 1'b0, 1'b1, 5'd20, 1'b1, 1'b1, 5'd0, 1'b0, 1'b1, 1'b0, 1'b0}, "seq R4");
    runVec('{5'd1, 5'd20, 1'b0, 1'b1, 5'd0, 1'b0, 1'b0, 5'd20, 1'b1, 1'b0, 1'b0, 1'b1}, "seq R5");

    // mid-run reset clears a held select (R8)
    runVec(VEC[7], "pre-reset R1");
    @(negedge clk);
    rstN = 1'b0;
    #1;
    chk("R8 async reset selA", int'(fwdSelA), 0);
    chk("R8 async reset selB", int'(fwdSelB), 0);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule